// File: doc/BRIEF.md
# Multi-speed SCL timing generator

This block derives the serial clock of a two-wire bus master from the system clock, and it times the data line around that clock. The block has three speed classes: standard, fast and high speed. Each class has its own pair of high-count and low-count registers. A two-bit speed field chooses the pair that sets the next clock period. Inside each low phase the block raises a one-cycle strobe that marks where the data line may change. This point trails the falling edge of SCL by a programmable hold delay. Inside each high phase a second strobe marks the middle of the phase, where the data line is read.

The generator starts when the run request is raised. At the end of every high phase it tests the run request again. If the request has been removed, the generator stops and leaves SCL high. During a high phase the counter waits for the sampled SCL line to read high. This lets a slave stretch the clock. The setup-time value is accepted at the port, but it only applies to target-side operation, so this master-only generator ignores it. All pins are plain level or strobe signals; no data flows through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `sclgen_top`

## Requirements
- R1: While reset is asserted and after its release with run low, scl_out is 1 and both strobes are 0.
- R2: The speed field is read as follows: 1 selects the standard pair, 2 the fast pair and 3 the high-speed pair. Value 0 behaves like 1. Only the selected pair affects the timing. The selection and the hold value are captured at the start of each low phase.
- R3: Each low phase lasts max(L, 8) + 1 system clocks, where L is the selected low count, so low counts below 8 act as 8.
- R4: Without stretching, each high phase lasts max(H, 6) + 8 system clocks, where H is the selected high count, so high counts below 6 act as 6.
- R5: sda_drive_strobe is high for exactly one cycle per low phase. Counting the first low cycle as index 0, it fires at index min(D + 2, lowlen - 1), where D is the hold value and lowlen is the low-phase length.
- R6: sda_sample_strobe is high for exactly one cycle per high phase. Counting the first high cycle as index 0 and with no stretching, it fires at index floor(highlen / 2).
- R7: During a high phase the counter does not advance in any cycle in which scl_in is 0. A stretch of S cycles at the start of the high phase therefore lengthens the phase by S and delays the sample strobe by S.
- R8: From idle, SCL falls in the first cycle after run is seen high. If run is low when a high phase ends, SCL stays high and no strobe fires until run returns.
- R9: The setup-time input has no effect on scl_out or either strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Request to keep generating clock periods |
| speed | input | 2 | Speed class select (1 standard, 2 fast, 3 high speed) |
| std_hcnt | input | CNT_W | Standard-class high count |
| std_lcnt | input | CNT_W | Standard-class low count |
| fast_hcnt | input | CNT_W | Fast-class high count |
| fast_lcnt | input | CNT_W | Fast-class low count |
| hs_hcnt | input | CNT_W | High-speed-class high count |
| hs_lcnt | input | CNT_W | High-speed-class low count |
| hold_cnt | input | HOLD_W | Data hold delay after SCL falls |
| setup_cnt | input | SETUP_W | Data setup value (target side only; ignored) |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_out | output | 1 | SCL drive level (1 = released high) |
| sda_drive_strobe | output | 1 | One-cycle pulse where SDA may change |
| sda_sample_strobe | output | 1 | One-cycle pulse where SDA is read |

## Verification
The assertions check several properties on every cycle. The drive strobe appears only while SCL is low and the sample strobe only while SCL is high and the line reads high. The phase counter stays inside the latched low length. The counter freezes in every cycle in which a slave holds the line low. The clamped lengths never fall below their floors. The generator parks high when a period ends with run removed. Exact phase lengths, strobe positions, speed-class selection, the effect of a stretch on period length, and the fact that the setup value has no effect show only in the bench scenarios. There, a scoreboard compares each measured low and high run against the values computed from the programmed registers.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

  typedef enum logic [1:0] {
    SPD_RSVD = 2'd0,
    SPD_STD  = 2'd1,
    SPD_FAST = 2'd2,
    SPD_HS   = 2'd3
  } speed_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  localparam int NUM_MODES = 3;

  // Map the speed field onto a register-pair index; reserved 0 acts as standard.
  function automatic logic [1:0] mode_index(input logic [1:0] spd);
    case (speed_e'(spd))
      SPD_FAST: return 2'd1;
      SPD_HS:   return 2'd2;
      default:  return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/sclgen_limit_sel.sv
module sclgen_limit_sel
  import sclgen_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int LEN_W    = 18,
  parameter int LOW_MIN  = 8,
  parameter int HIGH_MIN = 6,
  parameter int LOW_ADD  = 1,
  parameter int HIGH_ADD = 8
) (
  input  logic [1:0]                      speed,
  input  logic [NUM_MODES-1:0][CNT_W-1:0] hcnt_v,
  input  logic [NUM_MODES-1:0][CNT_W-1:0] lcnt_v,
  output logic [LEN_W-1:0]                low_len,
  output logic [LEN_W-1:0]                high_len
);

  logic [LEN_W-1:0] low_m  [NUM_MODES];
  logic [LEN_W-1:0] high_m [NUM_MODES];
  logic [1:0]       sel;

  // One clamp-and-offset stage per speed class.
  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    logic [LEN_W-1:0] l_ext;
    logic [LEN_W-1:0] h_ext;
    assign l_ext = LEN_W'(lcnt_v[m]);
    assign h_ext = LEN_W'(hcnt_v[m]);
    assign low_m[m]  = ((l_ext < LEN_W'(LOW_MIN))  ? LEN_W'(LOW_MIN)  : l_ext)
                       + LEN_W'(LOW_ADD);
    assign high_m[m] = ((h_ext < LEN_W'(HIGH_MIN)) ? LEN_W'(HIGH_MIN) : h_ext)
                       + LEN_W'(HIGH_ADD);
  end

  assign sel      = mode_index(speed);
  assign low_len  = low_m[sel];
  assign high_len = high_m[sel];

endmodule

// File: rtl/sclgen_phase_ctl.sv
module sclgen_phase_ctl
  import sclgen_pkg::*;
#(
  parameter int LEN_W    = 18,
  parameter int HOLD_W   = 16,
  parameter int HOLD_ADD = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              scl_in,
  input  logic [LEN_W-1:0]  low_len,
  input  logic [LEN_W-1:0]  high_len,
  input  logic [HOLD_W-1:0] hold_cnt,
  output logic              scl_out,
  output logic              sda_drive_strobe,
  output logic              sda_sample_strobe
);

  phase_e           phase_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] low_q;
  logic [LEN_W-1:0] high_q;
  logic [LEN_W-1:0] dpt_q;
  logic [LEN_W-1:0] hold_ext;
  logic [LEN_W-1:0] dpt_d;
  logic             low_end;
  logic             high_end;
  logic             start_low;

  // Drive point: hold plus fixed offset, capped at the last low cycle.
  assign hold_ext = LEN_W'(hold_cnt) + LEN_W'(HOLD_ADD);
  assign dpt_d    = (hold_ext > (low_len - LEN_W'(1))) ? (low_len - LEN_W'(1)) : hold_ext;

  assign low_end   = (phase_q == PH_LOW) && (cnt_q == low_q - LEN_W'(1));
  assign high_end  = (phase_q == PH_HIGH) && scl_in && (cnt_q == high_q - LEN_W'(1));
  assign start_low = run && ((phase_q == PH_IDLE) || high_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      low_q   <= '0;
      high_q  <= '0;
      dpt_q   <= '0;
    end else if (start_low) begin
      phase_q <= PH_LOW;
      cnt_q   <= '0;
      low_q   <= low_len;
      high_q  <= high_len;
      dpt_q   <= dpt_d;
    end else if (low_end) begin
      phase_q <= PH_HIGH;
      cnt_q   <= '0;
    end else if (high_end) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if ((phase_q == PH_LOW) || ((phase_q == PH_HIGH) && scl_in)) begin
      cnt_q <= cnt_q + LEN_W'(1);
    end
  end

  assign scl_out           = (phase_q != PH_LOW);
  assign sda_drive_strobe  = (phase_q == PH_LOW) && (cnt_q == dpt_q);
  assign sda_sample_strobe = (phase_q == PH_HIGH) && scl_in && (cnt_q == (high_q >> 1));

  a_r5_drive_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    sda_drive_strobe |-> !scl_out);

  a_r6_sample_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    sda_sample_strobe |-> (scl_out && scl_in));

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOW) |-> (cnt_q < low_q));

  a_r7_freeze_on_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_HIGH) && !scl_in) |=> ($stable(cnt_q) && (phase_q == PH_HIGH)));

  a_r8_park_high: assert property (@(posedge clk) disable iff (!rst_n)
    (high_end && !run) |=> (scl_out && !sda_drive_strobe && (phase_q == PH_IDLE)));

endmodule

// File: rtl/sclgen_top.sv
module sclgen_top
  import sclgen_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int HOLD_W   = 16,
  parameter int SETUP_W  = 8,
  parameter int LOW_MIN  = 8,
  parameter int HIGH_MIN = 6,
  parameter int LOW_ADD  = 1,
  parameter int HIGH_ADD = 8,
  parameter int HOLD_ADD = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [1:0]         speed,
  input  logic [CNT_W-1:0]   std_hcnt,
  input  logic [CNT_W-1:0]   std_lcnt,
  input  logic [CNT_W-1:0]   fast_hcnt,
  input  logic [CNT_W-1:0]   fast_lcnt,
  input  logic [CNT_W-1:0]   hs_hcnt,
  input  logic [CNT_W-1:0]   hs_lcnt,
  input  logic [HOLD_W-1:0]  hold_cnt,
  input  logic [SETUP_W-1:0] setup_cnt,
  input  logic               scl_in,
  output logic               scl_out,
  output logic               sda_drive_strobe,
  output logic               sda_sample_strobe
);

  localparam int LEN_W = ((CNT_W > HOLD_W) ? CNT_W : HOLD_W) + 2;

  logic [NUM_MODES-1:0][CNT_W-1:0] hcnt_v;
  logic [NUM_MODES-1:0][CNT_W-1:0] lcnt_v;
  logic [LEN_W-1:0]                low_len;
  logic [LEN_W-1:0]                high_len;
  logic                            setup_unused;

  // Setup time only matters on the target side; a master has no use for it.
  assign setup_unused = ^setup_cnt;

  assign hcnt_v = {hs_hcnt, fast_hcnt, std_hcnt};
  assign lcnt_v = {hs_lcnt, fast_lcnt, std_lcnt};

  sclgen_limit_sel #(
    .CNT_W   (CNT_W),
    .LEN_W   (LEN_W),
    .LOW_MIN (LOW_MIN),
    .HIGH_MIN(HIGH_MIN),
    .LOW_ADD (LOW_ADD),
    .HIGH_ADD(HIGH_ADD)
  ) u_limit (
    .speed   (speed),
    .hcnt_v  (hcnt_v),
    .lcnt_v  (lcnt_v),
    .low_len (low_len),
    .high_len(high_len)
  );

  sclgen_phase_ctl #(
    .LEN_W   (LEN_W),
    .HOLD_W  (HOLD_W),
    .HOLD_ADD(HOLD_ADD)
  ) u_phase (
    .clk              (clk),
    .rst_n            (rst_n),
    .run              (run),
    .scl_in           (scl_in),
    .low_len          (low_len),
    .high_len         (high_len),
    .hold_cnt         (hold_cnt),
    .scl_out          (scl_out),
    .sda_drive_strobe (sda_drive_strobe),
    .sda_sample_strobe(sda_sample_strobe)
  );

  a_r3_low_floor: assert property (@(posedge clk) disable iff (!rst_n)
    low_len >= LEN_W'(LOW_MIN + LOW_ADD));

  a_r4_high_floor: assert property (@(posedge clk) disable iff (!rst_n)
    high_len >= LEN_W'(HIGH_MIN + HIGH_ADD));

endmodule

// File: tb/test_sclgen_top.sv
module test_sclgen_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [1:0]  speed = 2'd1;
  logic [15:0] std_hcnt = 16'd0, std_lcnt = 16'd0;
  logic [15:0] fast_hcnt = 16'd0, fast_lcnt = 16'd0;
  logic [15:0] hs_hcnt = 16'd0, hs_lcnt = 16'd0;
  logic [15:0] hold_cnt = 16'd0;
  logic [7:0]  setup_cnt = 8'd0;
  logic        stretch = 1'b0;
  logic        scl_in;
  logic        scl_out, sda_drive_strobe, sda_sample_strobe;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  bit skip_high = 1;
  int stretch_cycles = 0;

  int    q_kind[$];
  int    q_len[$];
  int    q_pos[$];
  string q_tag[$];

  always #10 clk = ~clk;

  assign scl_in = scl_out & ~stretch;

  sclgen_top i_sclgen_top (
    .clk(clk), .rst_n(rst_n), .run(run), .speed(speed),
    .std_hcnt(std_hcnt), .std_lcnt(std_lcnt),
    .fast_hcnt(fast_hcnt), .fast_lcnt(fast_lcnt),
    .hs_hcnt(hs_hcnt), .hs_lcnt(hs_lcnt),
    .hold_cnt(hold_cnt), .setup_cnt(setup_cnt), .scl_in(scl_in),
    .scl_out(scl_out), .sda_drive_strobe(sda_drive_strobe),
    .sda_sample_strobe(sda_sample_strobe)
  );

  task automatic report(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // Slave model: holds SCL low for stretch_cycles at the start of each high phase.
  initial begin
    bit prev = 1'b1;
    int left = 0;
    forever begin
      @(negedge clk);
      if (left > 0) begin
        left--;
        if (left == 0) stretch = 1'b0;
      end else if (scl_out && !prev && stretch_cycles > 0) begin
        stretch = 1'b1;
        left = stretch_cycles;
      end
      prev = scl_out;
    end
  end

  // Monitor: measures every low run and every following high run, compares to the queue.
  task automatic emit(input int kind, input int len, input int pos);
    if (q_kind.size() == 0) begin
      report(0, $sformatf("R8 unexpected phase kind=%0d len", kind), len, 0);
    end else begin
      int ek = q_kind.pop_front();
      int el = q_len.pop_front();
      int ep = q_pos.pop_front();
      string et = q_tag.pop_front();
      report(ek == kind && el == len, {et, " phase length"}, len, el);
      report(ep == pos, {et, " strobe index"}, pos, ep);
    end
  endtask

  initial begin
    bit prev_scl = 1'b1;
    int run_len = 0;
    int spos = -1;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (scl_out != prev_scl) begin
          if (!prev_scl) emit(0, run_len, spos);
          else if (skip_high) skip_high = 0;
          else emit(1, run_len, spos);
          run_len = 0;
          spos = -1;
        end
        if ((!scl_out && sda_sample_strobe) || (scl_out && sda_drive_strobe))
          report(0, "R5 R6 strobe in wrong phase", 1, 0);
        if ((scl_out && sda_sample_strobe) || (!scl_out && sda_drive_strobe)) begin
          if (spos >= 0) report(0, "R5 R6 second strobe in one phase", run_len, spos);
          else spos = run_len;
        end
        run_len++;
        prev_scl = scl_out;
      end
    end
  end

  // Driver: pushes expected runs, runs n periods, then checks the parked state.
  task automatic run_case(input string tag, input int n, input int lo, input int dp,
                          input int hi, input int sp, input int st);
    stretch_cycles = st;
    for (int i = 0; i < n; i++) begin
      q_kind.push_back(0); q_len.push_back(lo); q_pos.push_back(dp);
      q_tag.push_back({tag, " R3 R5 low"});
      if (i < n - 1) begin
        q_kind.push_back(1); q_len.push_back(hi + st); q_pos.push_back(sp + st);
        q_tag.push_back({tag, " R4 R6 R7 high"});
      end
    end
    @(negedge clk);
    run = 1'b1;
    repeat (n) @(negedge scl_out);
    @(negedge clk);
    run = 1'b0;
    repeat (lo + hi + st + 5) @(negedge clk);
    begin
      bit bad = 0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        #2;
        if (!scl_out || sda_drive_strobe || sda_sample_strobe) bad = 1;
      end
      report(!bad, {tag, " R8 parked high after run drop"}, bad, 0);
    end
    skip_high = 1;
    stretch_cycles = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    report(0, "watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    report(scl_out && !sda_drive_strobe && !sda_sample_strobe, "R1 outputs in reset",
           {scl_out, sda_drive_strobe, sda_sample_strobe}, 3'b100);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    #2;
    report(scl_out && !sda_drive_strobe && !sda_sample_strobe, "R1 idle after reset",
           {scl_out, sda_drive_strobe, sda_sample_strobe}, 3'b100);

    // Standard pair, other pairs set to distinct values (R2).
    std_lcnt = 16'd20; std_hcnt = 16'd10;
    fast_lcnt = 16'd30; fast_hcnt = 16'd30;
    hs_lcnt = 16'd40; hs_hcnt = 16'd40;
    hold_cnt = 16'd3; speed = 2'd1;
    run_case("R2 standard", 3, 21, 5, 18, 9, 0);

    // Fast pair at its floor, setup value changed (R9).
    fast_lcnt = 16'd8; fast_hcnt = 16'd6; hold_cnt = 16'd0;
    setup_cnt = 8'd255; speed = 2'd2;
    run_case("R2 R9 fast", 3, 9, 2, 14, 7, 0);

    // High-speed pair below the floor: clamped.
    hs_lcnt = 16'd3; hs_hcnt = 16'd2; speed = 2'd3;
    run_case("R2 clamp high-speed", 2, 9, 2, 14, 7, 0);

    // Reserved speed code acts as standard.
    hold_cnt = 16'd3; speed = 2'd0; setup_cnt = 8'd0;
    run_case("R2 reserved code", 2, 21, 5, 18, 9, 0);

    // Hold longer than the low phase: strobe on the last low cycle.
    std_lcnt = 16'd10; std_hcnt = 16'd6; hold_cnt = 16'd20; speed = 2'd1;
    run_case("R5 long hold", 2, 11, 10, 14, 7, 0);

    // Slave stretches each high phase by 5 cycles.
    hold_cnt = 16'd1; speed = 2'd2;
    run_case("R7 stretch", 3, 9, 3, 14, 7, 5);

    // Longer high phase.
    std_lcnt = 16'd9; std_hcnt = 16'd20; hold_cnt = 16'd0; speed = 2'd1;
    run_case("R4 R6 long high", 2, 10, 2, 28, 14, 0);

    report(q_kind.size() == 0, "R3 R4 all expected phases seen", q_kind.size(), 0);
    finish_run();
  end

endmodule